// File: doc/BRIEF.md
# Multi-Core Slice Bitstream Sequencer

This block joins the output of several intra-only video encoder cores that run side by side into one frame bitstream a decoder can read. Each core codes one horizontal band of the picture, and that band is a slice the decoder can handle on its own. The bands are stacked top to bottom, so each slice covers a run of macroblocks that is contiguous in raster scan order. Each core streams the bytes of its finished slice NAL unit into a private byte FIFO. The sequencer puts whole slices out in band order and never mixes bytes from two slices.

The host starts each frame with a request. When the request is marked as an IDR frame, the host also streams the two static parameter-set NAL units (sequence parameter set first, then picture parameter set) through a separate byte port. The sequencer forwards them before the slices. Every NAL unit on the output gets a four-byte start code in front of it. Payload bytes pass through unchanged, because emulation prevention has already been applied upstream. With the default geometry (352x288 picture, 16x16 macroblocks, 22 columns by 18 rows, two cores), each band is 9 macroblock rows, or 198 macroblocks. The second slice therefore begins at macroblock address 198. The band split is checked against the parameters.

Top module: `slice_stream_sequencer`

## Requirements
- R1: After reset, `bs_valid` is low, `prm_ready` is low, `frm_ready` is high and every `core_ready` bit is high.
- R2: For an IDR frame the output carries the parameter-set NAL units in the order the host supplies them, then the slice of core 0, then core 1, up to core N_CORES-1. Each slice is emitted whole and unchanged.
- R3: Every NAL unit on the output is preceded by the start code bytes 0x00, 0x00, 0x00, 0x01, in that order. A NAL unit ends at the byte that was marked with the end-of-NAL flag on its input.
- R4: For a frame requested with `frm_idr` low, no parameter set is emitted and `prm_ready` stays low for the whole frame. The frame output is the slices only.
- R5: No byte of slice k+1 is emitted before the end-of-NAL byte of slice k, and only one source is drained in any cycle. A core whose slice is waiting keeps `core_ready` high until its FIFO holds FIFO_DEPTH bytes, and holds it low while the FIFO is full.
- R6: `bs_sof` is high with the first byte of each frame (the first start-code byte) and low on every other byte.
- R7: While `bs_valid` is high and `bs_ready` is low, the next cycle keeps `bs_valid` high and holds `bs_data` and `bs_sof` unchanged.
- R8: `frm_ready` is high only when no frame is in progress. A new frame request is accepted only after the last byte of the previous frame. When `frm_ready` is high, `bs_valid` and `prm_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_valid | input | 1 | Host requests a new frame |
| frm_idr | input | 1 | With `frm_valid`: frame is IDR, so parameter sets precede the slices |
| frm_ready | output | 1 | Sequencer is idle and accepts a frame request |
| prm_valid | input | 1 | Parameter-set byte valid |
| prm_data | input | 8 | Parameter-set byte |
| prm_last | input | 1 | Marks the last byte of a parameter-set NAL unit |
| prm_ready | output | 1 | Parameter-set byte is taken this cycle |
| core_valid | input | N_CORES | Per-core slice byte valid |
| core_data | input | 8*N_CORES | Per-core slice byte, core k in bits 8k+7:8k |
| core_last | input | N_CORES | Per-core end-of-NAL marker |
| core_ready | output | N_CORES | Per-core FIFO not full |
| bs_valid | output | 1 | Output byte valid |
| bs_data | output | 8 | Output bitstream byte |
| bs_sof | output | 1 | First byte of a frame |
| bs_ready | input | 1 | Downstream accepts the output byte |

## Verification
The bench holds back core 0 while core 1 fills its FIFO. This shows that a waiting slice is buffered up to exactly FIFO_DEPTH bytes and then back-pressured, instead of leaking into the output. A design that interleaves or starts from the wrong core would emit slice-1 bytes inside slice 0. Frames alternate between IDR and non-IDR with random payload lengths down to a single byte, and random stalls are applied on every port. Under these conditions a missing or doubled start code, a preamble emitted in a non-IDR frame, a start-of-frame flag on the wrong byte, or an output byte that changes under back-pressure each shows up as a byte-level miscompare against the queue the bench builds.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CODE = 2'd1,
    ST_BODY = 2'd2
  } seq_state_e;

  localparam int CODE_LEN = 4;

  function automatic logic [7:0] code_byte(input logic [1:0] idx);
    return (idx == 2'd3) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/seq_byte_fifo.sv
module seq_byte_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             push, pop, ptr_en;

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign push      = in_valid & in_ready;
  assign pop       = out_pop & out_valid;
  assign ptr_en    = push | pop;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_data;
  end
endmodule

// File: rtl/seq_src_mux.sv
module seq_src_mux #(
  parameter int N_CORES = 2,
  parameter int SELW    = 2
) (
  input  logic [SELW-1:0]      sel,
  input  logic                 in_body,
  input  logic                 bs_ready,
  input  logic                 prm_valid,
  input  logic [7:0]           prm_data,
  input  logic                 prm_last,
  output logic                 prm_ready,
  input  logic [N_CORES-1:0]   fifo_valid,
  input  logic [N_CORES*8-1:0] fifo_data,
  input  logic [N_CORES-1:0]   fifo_last,
  output logic [N_CORES-1:0]   fifo_pop,
  output logic                 src_valid,
  output logic [7:0]           src_data,
  output logic                 src_last
);
  always_comb begin
    src_valid = 1'b0;
    src_data  = 8'h00;
    src_last  = 1'b0;
    if (sel == '0) begin
      src_valid = prm_valid;
      src_data  = prm_data;
      src_last  = prm_last;
    end
    for (int k = 0; k < N_CORES; k++) begin
      if (sel == SELW'(k + 1)) begin
        src_valid = fifo_valid[k];
        src_data  = fifo_data[k*8 +: 8];
        src_last  = fifo_last[k];
      end
    end
  end

  assign prm_ready = in_body & bs_ready & (sel == '0);

  for (genvar k = 0; k < N_CORES; k++) begin : g_pop
    assign fifo_pop[k] = in_body & bs_ready & fifo_valid[k] & (sel == SELW'(k + 1));
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int N_CORES  = 2,
  parameter int PRM_NALS = 2,
  parameter int SELW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_valid,
  input  logic            frm_idr,
  output logic            frm_ready,
  input  logic            bs_ready,
  input  logic            src_valid,
  input  logic            src_last,
  output logic [SELW-1:0] sel,
  output logic            in_code,
  output logic            in_body,
  output logic [7:0]      code_out,
  output logic            sof_pend
);
  localparam int NW = (PRM_NALS > 1) ? $clog2(PRM_NALS) : 1;

  seq_state_e      st_q, st_n;
  logic [SELW-1:0] sel_q, sel_n;
  logic [NW-1:0]   nal_q, nal_n;
  logic [1:0]      cnt_q, cnt_n;
  logic            sof_q, sof_n;
  logic            upd;

  assign upd = (st_q == ST_IDLE) ? frm_valid : bs_ready;

  always_comb begin
    st_n  = st_q;
    sel_n = sel_q;
    nal_n = nal_q;
    cnt_n = cnt_q;
    sof_n = sof_q;
    case (st_q)
      ST_IDLE: begin
        if (frm_valid) begin
          st_n  = ST_CODE;
          sel_n = frm_idr ? '0 : SELW'(1);
          nal_n = '0;
          cnt_n = '0;
          sof_n = 1'b1;
        end
      end
      ST_CODE: begin
        sof_n = 1'b0;
        if (cnt_q == 2'(CODE_LEN - 1)) begin
          st_n  = ST_BODY;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_BODY: begin
        if (src_valid && src_last) begin
          if (sel_q == '0) begin
            st_n = ST_CODE;
            if (nal_q == NW'(PRM_NALS - 1)) sel_n = SELW'(1);
            else                            nal_n = nal_q + 1'b1;
          end else if (sel_q == SELW'(N_CORES)) begin
            st_n = ST_IDLE;
          end else begin
            st_n  = ST_CODE;
            sel_n = sel_q + 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      nal_q <= '0;
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else if (upd) begin
      st_q  <= st_n;
      sel_q <= sel_n;
      nal_q <= nal_n;
      cnt_q <= cnt_n;
      sof_q <= sof_n;
    end
  end

  assign frm_ready = (st_q == ST_IDLE);
  assign in_code   = (st_q == ST_CODE);
  assign in_body   = (st_q == ST_BODY);
  assign sel       = sel_q;
  assign code_out  = code_byte(cnt_q);
  assign sof_pend  = sof_q;
endmodule

// File: rtl/slice_stream_sequencer.sv
module slice_stream_sequencer #(
  parameter int N_CORES    = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int PRM_NALS   = 2,
  parameter int PIC_W      = 352,
  parameter int PIC_H      = 288,
  parameter int MB_SIZE    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_valid,
  input  logic                 frm_idr,
  output logic                 frm_ready,
  input  logic                 prm_valid,
  input  logic [7:0]           prm_data,
  input  logic                 prm_last,
  output logic                 prm_ready,
  input  logic [N_CORES-1:0]   core_valid,
  input  logic [N_CORES*8-1:0] core_data,
  input  logic [N_CORES-1:0]   core_last,
  output logic [N_CORES-1:0]   core_ready,
  output logic                 bs_valid,
  output logic [7:0]           bs_data,
  output logic                 bs_sof,
  input  logic                 bs_ready
);
  localparam int SELW      = $clog2(N_CORES + 1);
  localparam int MB_COLS   = PIC_W / MB_SIZE;
  localparam int MB_ROWS   = PIC_H / MB_SIZE;
  localparam int BAND_ROWS = MB_ROWS / N_CORES;
  localparam int BAND_MB   = BAND_ROWS * MB_COLS;

  logic                 rst_s_n;
  logic [SELW-1:0]      sel;
  logic                 in_code, in_body, sof_pend;
  logic [7:0]           code_out;
  logic                 src_valid, src_last;
  logic [7:0]           src_data;
  logic [N_CORES-1:0]   fifo_valid, fifo_last, fifo_pop;
  logic [N_CORES*8-1:0] fifo_data;

  seq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    logic [8:0] rd_word;
    seq_byte_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .in_valid  (core_valid[k]),
      .in_data   ({core_last[k], core_data[k*8 +: 8]}),
      .in_ready  (core_ready[k]),
      .out_valid (fifo_valid[k]),
      .out_data  (rd_word),
      .out_pop   (fifo_pop[k])
    );
    assign fifo_last[k]        = rd_word[8];
    assign fifo_data[k*8 +: 8] = rd_word[7:0];
  end

  seq_src_mux #(.N_CORES(N_CORES), .SELW(SELW)) u_mux (
    .sel        (sel),
    .in_body    (in_body),
    .bs_ready   (bs_ready),
    .prm_valid  (prm_valid),
    .prm_data   (prm_data),
    .prm_last   (prm_last),
    .prm_ready  (prm_ready),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_last  (fifo_last),
    .fifo_pop   (fifo_pop),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_last   (src_last)
  );

  seq_ctrl #(.N_CORES(N_CORES), .PRM_NALS(PRM_NALS), .SELW(SELW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .frm_valid (frm_valid),
    .frm_idr   (frm_idr),
    .frm_ready (frm_ready),
    .bs_ready  (bs_ready),
    .src_valid (src_valid),
    .src_last  (src_last),
    .sel       (sel),
    .in_code   (in_code),
    .in_body   (in_body),
    .code_out  (code_out),
    .sof_pend  (sof_pend)
  );

  assign bs_valid = in_code | (in_body & src_valid);
  assign bs_data  = in_code ? code_out : src_data;
  assign bs_sof   = sof_pend & bs_valid;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int N_CORES = 2,
  parameter int MB_ROWS = 18,
  parameter int MB_COLS = 22,
  parameter int BAND_MB = 198
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               bs_valid,
  input logic               bs_ready,
  input logic [7:0]         bs_data,
  input logic               bs_sof,
  input logic               frm_ready,
  input logic               prm_valid,
  input logic               prm_ready,
  input logic [N_CORES-1:0] fifo_pop
);
  // R2: bands must tile the picture in whole macroblock rows
  initial begin
    assert_band_geometry_R2: assert ((MB_ROWS % N_CORES) == 0 && BAND_MB * N_CORES == MB_ROWS * MB_COLS)
      else $error("band split does not tile the picture");
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bs_valid && !bs_ready |=> bs_valid && $stable(bs_data) && $stable(bs_sof));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    frm_ready |-> !bs_valid && !prm_ready);

  assert_sof_code_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    bs_sof |-> bs_valid && bs_data == 8'h00);

  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({prm_valid & prm_ready, fifo_pop}));
endmodule

bind slice_stream_sequencer seq_checker #(
  .N_CORES (N_CORES),
  .MB_ROWS (MB_ROWS),
  .MB_COLS (MB_COLS),
  .BAND_MB (BAND_MB)
) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .bs_valid  (bs_valid),
  .bs_ready  (bs_ready),
  .bs_data   (bs_data),
  .bs_sof    (bs_sof),
  .frm_ready (frm_ready),
  .prm_valid (prm_valid),
  .prm_ready (prm_ready),
  .fifo_pop  (fifo_pop)
);

// File: tb/tb_slice_stream_sequencer.sv
module tb_slice_stream_sequencer;
  localparam int NC    = 2;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic frm_valid, frm_idr, prm_valid, prm_last, bs_ready;
  logic [7:0] prm_data;
  wire  frm_ready, prm_ready, bs_valid, bs_sof;
  wire  [7:0] bs_data;
  logic cv [NC];
  logic cl [NC];
  logic [7:0] cd [NC];
  logic [NC-1:0]   core_valid, core_last;
  logic [NC*8-1:0] core_data;
  wire  [NC-1:0]   core_ready;

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      core_valid[k]       = cv[k];
      core_last[k]        = cl[k];
      core_data[k*8 +: 8] = cd[k];
    end
  end

  slice_stream_sequencer #(.N_CORES(NC), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_idr(frm_idr), .frm_ready(frm_ready),
    .prm_valid(prm_valid), .prm_data(prm_data), .prm_last(prm_last), .prm_ready(prm_ready),
    .core_valid(core_valid), .core_data(core_data), .core_last(core_last), .core_ready(core_ready),
    .bs_valid(bs_valid), .bs_data(bs_data), .bs_sof(bs_sof), .bs_ready(bs_ready)
  );

  int vecs = 0;
  int errs = 0;
  logic [7:0] exp_q [$];
  bit         exp_sof [$];
  logic [7:0] prm_buf [2][$];
  logic [7:0] sl_buf [NC][$];
  bit frame_active = 0, frame_idr = 0, frm_taken = 0;
  bit r4_bad = 0, r8_bad = 0, done = 0;
  bit prev_stall = 0, prev_sof = 0;
  logic [7:0] prev_data = 8'h00;

  task automatic push_code();
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    exp_q.push_back(8'h00); exp_q.push_back(8'h01);
    for (int i = 0; i < 4; i++) exp_sof.push_back(1'b0);
  endtask

  // output monitor: byte order, start codes, sof, stall hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        vecs++;
        if (!bs_valid || bs_data !== prev_data || bs_sof !== prev_sof) begin
          errs++;
          $display("FAIL R7 stall hold: actual v=%0b d=%h s=%0b expected v=1 d=%h s=%0b",
                   bs_valid, bs_data, bs_sof, prev_data, prev_sof);
        end
      end
      if (bs_valid && bs_ready) begin
        vecs++;
        if (exp_q.size() == 0) begin
          errs++;
          $display("FAIL R2 unexpected byte: actual %h expected none", bs_data);
        end else begin
          logic [7:0] e;
          bit es;
          e  = exp_q.pop_front();
          es = exp_sof.pop_front();
          if (bs_data !== e) begin
            errs++;
            $display("FAIL R2 R3 byte: actual %h expected %h", bs_data, e);
          end
          if (bs_sof !== es) begin
            errs++;
            $display("FAIL R6 sof: actual %0b expected %0b", bs_sof, es);
          end
        end
      end
      prev_stall = bs_valid && !bs_ready;
      prev_data  = bs_data;
      prev_sof   = bs_sof;
      if (frame_active && !frame_idr && prm_ready) r4_bad = 1;
      if (frm_taken && exp_q.size() > 0 && frm_ready) r8_bad = 1;
    end
  end

  initial begin
    bs_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      bs_ready = ($urandom % 4) != 0;
    end
  end

  task automatic drive_frame_req(input bit idr);
    frm_valid = 1'b1; frm_idr = idr;
    forever begin @(negedge clk); if (frm_ready) break; @(posedge clk); #1; end
    @(posedge clk); #1;
    frm_valid = 1'b0;
    frm_taken = 1;
  endtask

  task automatic drive_prm();
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < prm_buf[n].size(); i++) begin
        prm_valid = 1'b1; prm_data = prm_buf[n][i]; prm_last = (i == prm_buf[n].size() - 1);
        forever begin @(negedge clk); if (prm_ready) break; @(posedge clk); #1; end
        @(posedge clk); #1;
        prm_valid = 1'b0;
        if ($urandom % 4 == 0) begin @(posedge clk); #1; end
      end
    end
  endtask

  task automatic drive_core(input int k, input bit special);
    if (special && k == 0) repeat (60) begin @(posedge clk); #1; end
    for (int i = 0; i < sl_buf[k].size(); i++) begin
      cv[k] = 1'b1; cd[k] = sl_buf[k][i]; cl[k] = (i == sl_buf[k].size() - 1);
      if (special && k == 1 && i < DEPTH) begin
        @(negedge clk);
        vecs++;
        if (!core_ready[1]) begin
          errs++;
          $display("FAIL R5 ready before full at byte %0d: actual 0 expected 1", i);
        end
        @(posedge clk); #1;
      end else begin
        if (special && k == 1 && i == DEPTH) begin
          for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            vecs++;
            if (core_ready[1]) begin
              errs++;
              $display("FAIL R5 ready while full: actual 1 expected 0");
            end
            @(posedge clk); #1;
          end
        end
        forever begin @(negedge clk); if (core_ready[k]) break; @(posedge clk); #1; end
        @(posedge clk); #1;
      end
      cv[k] = 1'b0;
      if (!special && $urandom % 3 == 0) repeat ($urandom % 3) begin @(posedge clk); #1; end
    end
  endtask

  task automatic run_frame(input bit idr, input bit special, input int maxlen);
    for (int n = 0; n < 2; n++) begin
      prm_buf[n].delete();
      for (int i = 0; i < 3 + $urandom % 6; i++) prm_buf[n].push_back(8'(1 + $urandom % 255));
    end
    for (int k = 0; k < NC; k++) begin
      int len;
      sl_buf[k].delete();
      len = special ? ((k == 1) ? 30 : 12) : 1 + $urandom % maxlen;
      for (int i = 0; i < len; i++) sl_buf[k].push_back(8'(1 + $urandom % 255));
    end
    // expected stream built from R2/R3/R6
    if (idr)
      for (int n = 0; n < 2; n++) begin
        push_code();
        foreach (prm_buf[n][i]) begin exp_q.push_back(prm_buf[n][i]); exp_sof.push_back(1'b0); end
      end
    for (int k = 0; k < NC; k++) begin
      push_code();
      foreach (sl_buf[k][i]) begin exp_q.push_back(sl_buf[k][i]); exp_sof.push_back(1'b0); end
    end
    exp_sof[0] = 1'b1;
    r4_bad = 0; r8_bad = 0;
    frame_idr = idr; frame_active = 1;
    fork
      begin drive_frame_req(idr); if (idr) drive_prm(); end
      drive_core(0, special);
      drive_core(1, special);
    join
    while (exp_q.size() > 0) begin @(posedge clk); #1; end
    repeat (3) begin @(posedge clk); #1; end
    @(negedge clk);
    vecs++;
    if (!frm_ready) begin
      errs++;
      $display("FAIL R8 idle after frame: actual frm_ready=0 expected 1");
    end
    vecs++;
    if (r8_bad) begin
      errs++;
      $display("FAIL R8 frm_ready during frame: actual 1 expected 0");
    end
    if (!idr) begin
      vecs++;
      if (r4_bad) begin
        errs++;
        $display("FAIL R4 prm_ready in non-IDR frame: actual 1 expected 0");
      end
    end
    frame_active = 0; frm_taken = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog: actual hung expected frames done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_idr = 1'b0;
    prm_valid = 1'b0; prm_data = 8'h00; prm_last = 1'b0;
    for (int k = 0; k < NC; k++) begin cv[k] = 1'b0; cd[k] = 8'h00; cl[k] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    @(negedge clk);
    vecs++;
    if (bs_valid !== 1'b0 || prm_ready !== 1'b0 || frm_ready !== 1'b1 || core_ready !== 2'b11) begin
      errs++;
      $display("FAIL R1 reset: actual v=%0b p=%0b f=%0b c=%b expected 0 0 1 11",
               bs_valid, prm_ready, frm_ready, core_ready);
    end
    @(posedge clk); #1;
    run_frame(1'b1, 1'b1, 40);   // R5 fill-and-hold with core 0 late
    run_frame(1'b0, 1'b0, 40);   // R4 non-IDR
    run_frame(1'b1, 1'b0, 1);    // single-byte slices
    run_frame(1'b0, 1'b0, 1);
    for (int f = 0; f < 40; f++) run_frame((f % 3) == 0, 1'b0, 40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule